// File: doc/BRIEF.md
# Fuse Array Byte Read Sequencer

This block walks a one-time-programmable fuse macro through a byte-by-byte read. A request gives a start byte offset and a byte count. The block first raises the macro into read mode. For each byte it then drives the address, strobes the macro and captures the macro's 8-bit output. Each captured byte leaves on a one-cycle valid pulse together with its data. When the run ends, the macro goes back to standby.

Every step is separated by the same settle interval, `SETTLE_CYC` clock cycles. The default of 200 cycles gives 1 µs at a 200 MHz clock. A single busy flag covers the whole run. A host issues one request, waits for busy to drop and then issues the next.

Pin conventions at the macro side:
- `fz_sel_n` is the active-low chip select.
- `fz_prog_n` is the active-low program enable. It is held high for every read.
- `fz_rd_en` is the load-to-read control.
- `fz_strobe` fires the read.

Top module: `fuse_rd_seq`

## Requirements
- R1: During and right after reset, and whenever `busy` is low, the macro pins are in standby: `fz_sel_n`=1, `fz_prog_n`=1, `fz_rd_en`=0, `fz_strobe`=0, with `byte_vld`=0.
- R2: One cycle after a request with a nonzero count is accepted, the pins show read mode: `fz_sel_n`=0, `fz_rd_en`=1, `fz_prog_n`=1, `fz_strobe`=0. The first strobe rise comes exactly 2·SETTLE_CYC cycles after acceptance (entry settle, then address settle).
- R3: The byte address on `fz_addr` is the low 10 bits of start offset plus byte index, so it wraps from 1023 to 0.
- R4: The address is stable with strobe low for at least SETTLE_CYC cycles before strobe rises. It is not changed while strobe is high.
- R5: Strobe stays high for exactly SETTLE_CYC cycles per byte. `byte_vld` pulses for one cycle in the cycle strobe drops, and `byte_data` carries the macro output seen in the last strobe-high cycle.
- R6: After strobe drops, it stays low for a further SETTLE_CYC cycles before the next address change or the return to standby. Byte k (counting from 0) is delivered 3·SETTLE_CYC·(k+1) cycles after acceptance.
- R7: Exactly `req_count` bytes are delivered, in increasing offset order, with one strobe pulse each.
- R8: `busy` drops in the same cycle the pins return to standby. For a nonzero count N, `busy` is high for SETTLE_CYC·(1+3N) cycles.
- R9: `busy` rises the cycle after acceptance. A `req_valid` presented while busy has no effect on the bytes, their addresses, the run length, or the state after the run.
- R10: A request with count 0 raises `busy` for one cycle and produces no strobe and no byte. The pins remain in standby throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_offset | input | ADDR_W (10) | Start byte offset |
| req_count | input | CNT_W (6) | Number of bytes to read |
| busy | output | 1 | High from acceptance until standby |
| byte_vld | output | 1 | One-cycle pulse per captured byte |
| byte_data | output | DATA_W (8) | Captured byte |
| fz_sel_n | output | 1 | Macro chip select, active low |
| fz_prog_n | output | 1 | Macro program enable, active low (kept high) |
| fz_rd_en | output | 1 | Macro load-to-read control |
| fz_strobe | output | 1 | Macro read strobe |
| fz_addr | output | ADDR_W (10) | Macro byte address |
| fz_dout | input | DATA_W (8) | Macro read data |

## Verification
Two situations are hard to reach from the ports. The first is a new request arriving in the middle of a run, where a wrong acceptance would silently redirect the address stream. The second is an offset running off the top of the 10-bit address space. The bench injects a one-cycle request partway through a run and checks that the bytes, addresses and busy length still match the original request. A vector starting at offset 1022 forces the wrap to 0. The behavioural fuse model returns zero unless chip select, read enable and strobe are all active, so a wrong pin order shows up as wrong data.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ADDR,
        ST_STRB,
        ST_HOLD,
        ST_ZERO
    } seq_state_e;
endpackage

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
    parameter int SETTLE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              tmr_expired,
    output logic              tmr_load,
    input  logic [DATA_W-1:0] fz_dout,
    output logic              busy,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              fz_sel_n,
    output logic              fz_prog_n,
    output logic              fz_rd_en,
    output logic              fz_strobe,
    output logic [ADDR_W-1:0] fz_addr
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] ofs;
        logic [CNT_W-1:0]  left;
        logic              sel_n;
        logic              prog_n;
        logic              rd_en;
        logic              strobe;
        logic [ADDR_W-1:0] addr;
        logic              busy;
        logic              vld;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    localparam seq_regs_t RST_VAL = '{
        st: ST_IDLE, ofs: '0, left: '0,
        sel_n: 1'b1, prog_n: 1'b1, rd_en: 1'b0, strobe: 1'b0,
        addr: '0, busy: 1'b0, vld: 1'b0, data: '0
    };

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        tmr_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.busy = 1'b1;
                    r_d.ofs  = req_offset;
                    r_d.left = req_count;
                    if (req_count == '0) begin
                        r_d.st = ST_ZERO;
                    end else begin
                        r_d.st     = ST_ENTER;
                        r_d.sel_n  = 1'b0;
                        r_d.prog_n = 1'b1;
                        r_d.rd_en  = 1'b1;
                        r_d.strobe = 1'b0;
                        tmr_load   = 1'b1;
                    end
                end
            end
            ST_ENTER: begin
                if (tmr_expired) begin
                    r_d.st   = ST_ADDR;
                    r_d.addr = r_q.ofs;
                    tmr_load = 1'b1;
                end
            end
            ST_ADDR: begin
                if (tmr_expired) begin
                    r_d.st     = ST_STRB;
                    r_d.strobe = 1'b1;
                    tmr_load   = 1'b1;
                end
            end
            ST_STRB: begin
                if (tmr_expired) begin
                    r_d.st     = ST_HOLD;
                    r_d.strobe = 1'b0;
                    r_d.vld    = 1'b1;
                    r_d.data   = fz_dout;
                    r_d.ofs    = r_q.ofs + 1'b1;
                    r_d.left   = r_q.left - 1'b1;
                    tmr_load   = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    if (r_q.left == '0) begin
                        r_d.st     = ST_IDLE;
                        r_d.busy   = 1'b0;
                        r_d.sel_n  = 1'b1;
                        r_d.prog_n = 1'b1;
                        r_d.rd_en  = 1'b0;
                        r_d.strobe = 1'b0;
                    end else begin
                        r_d.st   = ST_ADDR;
                        r_d.addr = r_q.ofs;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_ZERO: begin
                r_d.st   = ST_IDLE;
                r_d.busy = 1'b0;
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign busy      = r_q.busy;
    assign byte_vld  = r_q.vld;
    assign byte_data = r_q.data;
    assign fz_sel_n  = r_q.sel_n;
    assign fz_prog_n = r_q.prog_n;
    assign fz_rd_en  = r_q.rd_en;
    assign fz_strobe = r_q.strobe;
    assign fz_addr   = r_q.addr;
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
    parameter int SETTLE_CYC = 200,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [CNT_W-1:0]  req_count,
    output logic              busy,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              fz_sel_n,
    output logic              fz_prog_n,
    output logic              fz_rd_en,
    output logic              fz_strobe,
    output logic [ADDR_W-1:0] fz_addr,
    input  logic [DATA_W-1:0] fz_dout
);
    logic tmr_load;
    logic tmr_expired;

    fuse_rd_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    fuse_rd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_offset  (req_offset),
        .req_count   (req_count),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .fz_dout     (fz_dout),
        .busy        (busy),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .fz_sel_n    (fz_sel_n),
        .fz_prog_n   (fz_prog_n),
        .fz_rd_en    (fz_rd_en),
        .fz_strobe   (fz_strobe),
        .fz_addr     (fz_addr)
    );
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
    parameter int SETTLE_CYC = 200,
    parameter int ADDR_W     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              byte_vld,
    input logic              fz_sel_n,
    input logic              fz_prog_n,
    input logic              fz_rd_en,
    input logic              fz_strobe,
    input logic [ADDR_W-1:0] fz_addr
);
    localparam int CW = $clog2(4 * SETTLE_CYC + 2) + 1;

    logic [CW-1:0]     hi_q, lo_q, age_q;
    logic [ADDR_W-1:0] addr_prev_q;

    // Saturating run-length counters for strobe high, strobe low and address age.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q        <= '0;
            lo_q        <= '0;
            age_q       <= '0;
            addr_prev_q <= '0;
        end else begin
            hi_q <= fz_strobe ? ((hi_q != '1) ? hi_q + 1'b1 : hi_q) : '0;
            lo_q <= fz_strobe ? '0 : ((lo_q != '1) ? lo_q + 1'b1 : lo_q);
            if (fz_addr != addr_prev_q) age_q <= CW'(1);
            else if (age_q != '1)       age_q <= age_q + 1'b1;
            addr_prev_q <= fz_addr;
        end
    end

    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fz_sel_n && fz_prog_n && !fz_rd_en && !fz_strobe && !byte_vld));

    a_r2_read_mode_prog_high: assert property (@(posedge clk) disable iff (!rst_n)
        !fz_sel_n |-> (fz_prog_n && fz_rd_en && busy));

    a_r4_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_strobe) |-> (age_q >= CW'(SETTLE_CYC)));

    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fz_strobe && $past(fz_strobe)) |-> $stable(fz_addr));

    a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fz_strobe) |-> (hi_q == CW'(SETTLE_CYC)));

    a_r5_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $fell(fz_strobe));

    a_r6_low_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_strobe) |-> (lo_q >= CW'(2 * SETTLE_CYC)));

    a_r6_low_before_standby: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(fz_rd_en)) |-> (lo_q >= CW'(SETTLE_CYC)));
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.SETTLE_CYC(SETTLE_CYC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .byte_vld  (byte_vld),
    .fz_sel_n  (fz_sel_n),
    .fz_prog_n (fz_prog_n),
    .fz_rd_en  (fz_rd_en),
    .fz_strobe (fz_strobe),
    .fz_addr   (fz_addr)
);

// File: tb/fuse_rd_seq_test.sv
`timescale 1ns/1ps
module fuse_rd_seq_test;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_offset = '0;
    logic [5:0] req_count = '0;
    logic       busy, byte_vld, fz_sel_n, fz_prog_n, fz_rd_en, fz_strobe;
    logic [7:0] byte_data, fz_dout;
    logic [9:0] fz_addr;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fval(input logic [9:0] a);
        return (a[7:0] * 8'd37) ^ 8'hC3 ^ {6'd0, a[9:8]};
    endfunction

    // Behavioural fuse array: data only when selected, in read mode and strobed.
    assign fz_dout = (!fz_sel_n && fz_rd_en && fz_strobe) ? fval(fz_addr) : 8'h00;

    fuse_rd_seq #(.SETTLE_CYC(S)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_count(req_count), .busy(busy), .byte_vld(byte_vld), .byte_data(byte_data),
        .fz_sel_n(fz_sel_n), .fz_prog_n(fz_prog_n), .fz_rd_en(fz_rd_en),
        .fz_strobe(fz_strobe), .fz_addr(fz_addr), .fz_dout(fz_dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int standby();
        return (fz_sel_n && fz_prog_n && !fz_rd_en && !fz_strobe) ? 1 : 0;
    endfunction

    task automatic run_req(input logic [9:0] off, input logic [5:0] cnt, input int inject_at);
        int bcnt = 0;
        int nbytes = 0;
        int nrise = 0;
        logic prev_strb = 1'b0;
        logic [9:0] exp_a;
        @(negedge clk);
        req_valid = 1'b1; req_offset = off; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        if (cnt != 0)
            check(!fz_sel_n && fz_rd_en && fz_prog_n && !fz_strobe, "R2 read-mode entry pins",
                  int'({fz_sel_n, fz_rd_en, fz_prog_n, fz_strobe}), 4'b0110);
        else
            check(standby() == 1, "R10 zero count keeps standby", standby(), 1);
        while (busy && bcnt < 5000) begin
            bcnt++;
            if (fz_strobe && !prev_strb) begin
                nrise++;
                if (nrise == 1) check(bcnt == 2*S+1, "R2 first strobe rise", bcnt, 2*S+1);
            end
            prev_strb = fz_strobe;
            if (byte_vld) begin
                exp_a = off + 10'(nbytes);
                check(fz_addr == exp_a, "R3 byte address", int'(fz_addr), int'(exp_a));
                check(byte_data == fval(exp_a), "R5 byte data", int'(byte_data), int'(fval(exp_a)));
                check(bcnt == 3*S*(nbytes+1)+1, "R6 byte timing", bcnt, 3*S*(nbytes+1)+1);
                nbytes++;
            end
            if (inject_at != 0 && bcnt == inject_at) begin
                req_valid = 1'b1; req_offset = off + 10'd7; req_count = 6'd2;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(nbytes == int'(cnt), "R7 byte count", nbytes, int'(cnt));
        check(nrise == int'(cnt), "R7 strobe pulses", nrise, int'(cnt));
        check(bcnt == ((cnt == 0) ? 1 : S*(1+3*int'(cnt))), "R8 busy length", bcnt,
              (cnt == 0) ? 1 : S*(1+3*int'(cnt)));
        check(standby() == 1, "R8 standby after run", standby(), 1);
        @(negedge clk); @(negedge clk);
        check(busy == 1'b0 && standby() == 1, "R9 no late start", int'(busy), 0);
    endtask

    localparam logic [15:0] VECS [7] = '{
        {10'd0,    6'd1}, {10'd5,  6'd4}, {10'd28,  6'd6}, {10'd1022, 6'd3},
        {10'd31,   6'd1}, {10'd100, 6'd2}, {10'd17, 6'd0}
    };

    initial begin
        repeat (3) @(negedge clk);
        check(standby() == 1 && !busy && !byte_vld, "R1 standby in reset", standby(), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(standby() == 1 && !busy && !byte_vld, "R1 standby after reset", standby(), 1);

        for (int i = 0; i < 7; i++)
            run_req(VECS[i][15:6], VECS[i][5:0], 0);

        // R9: a request during a run must be ignored
        run_req(10'd40, 6'd3, 2*S+2);
        // R10: zero count right after a run
        run_req(10'd3, 6'd0, 0);

        // R1: reset in the middle of a run returns to standby
        @(negedge clk);
        req_valid = 1'b1; req_offset = 10'd9; req_count = 6'd5;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2*S+2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(standby() == 1 && !busy, "R1 standby on mid-run reset", standby(), 1);
        @(negedge clk);
        rst_n = 1'b1;
        run_req(10'd12, 6'd2, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule